// File: doc/BRIEF.md
# Ping-pong prefetch buffer controller

This block sits between one compute engine and a shared memory bus and keeps the engine supplied with data from two local buffers, buffer 0 and buffer 1. At any moment one buffer faces the compute engine, which reads its operands from it and writes its results back in place. The other buffer faces the bus. It first writes the results of the segment it last held back to shared memory, then fills with the next input segment. When the compute engine reports that its segment is finished and the bus side has its next segment loaded, the two buffers trade places.

The work is a list of segments. Controlling logic supplies each segment as a descriptor, looked up by index: an input base, an output base, a row stride in words, a width in words and a height in rows. Each buffer has its own transfer engine. That engine walks the rectangle row by row and issues addresses `base + row*stride + col`. Segments may overlap in global memory because every descriptor carries its own bases. A pulse on `start` with a non-zero segment count begins a job. `busy` stays high until the last segment's results are in shared memory, and `done` then pulses once.

Top module: `pingpong_prefetch`

## Requirements
- R1: After reset `busy`, `done`, `bus_req` and `cpu_ready` are 0, and while `busy` is 0 neither `bus_req` nor `cpu_ready` is asserted.
- R2: `start` with a `seg_count` of 1 or more raises `busy` on the next clock. `start` is ignored when `seg_count` is 0 or when `busy` is already high.
- R3: A load moves the segment's words in row-major order, one word per cycle in which `bus_req` and `bus_gnt` are both high, with `bus_we`=0 and `bus_addr` = in_base + row*stride + col. `bus_rdata` is taken in that same cycle and lands at local index row*width+col, where the compute engine reads it on `cpu_rdata` in the same cycle as `cpu_addr`.
- R4: An unload writes one word per granted cycle with `bus_we`=1, `bus_addr` = out_base + row*stride + col, and `bus_wdata` equal to the word the compute engine last wrote at local index row*width+col.
- R5: Once raised, `bus_req` stays high with `bus_addr` and `bus_we` unchanged until a cycle in which `bus_gnt` is high.
- R6: Between the last write of an unload and the first read of the load that follows it, `bus_req` is low for at least one cycle.
- R7: Segment i is fetched with `desc_idx`=i. Segments are loaded in list order. Segment 0 goes into buffer 0 with no unload before it, and segment i is presented to the compute engine on buffer i mod 2 (`cpu_sel`).
- R8: On a buffer that held a segment, the unload of that segment completes before any word of the next segment is loaded into it.
- R9: `cpu_ready` rises only when the segment on `cpu_sel` is fully loaded. After an accepted `cpu_seg_done` it is low until the two buffers have swapped.
- R10: After the compute engine finishes the last segment, its results are unloaded. `done` is high for exactly one cycle, two cycles after the last write's granted cycle, and `busy` falls together with it.
- R11: While `cpu_ready` is low, `cpu_we` and `cpu_seg_done` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job (pulse) |
| seg_count | input | 8 | Number of segments in the job |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse when all results are written back |
| desc_idx | output | 8 | Index of the descriptor being fetched |
| desc_in_base | input | 16 | Global base of the segment's input rectangle |
| desc_out_base | input | 16 | Global base of the segment's result rectangle |
| desc_stride | input | 16 | Global words between rows |
| desc_width | input | 7 | Words per row (1 or more) |
| desc_height | input | 7 | Rows (1 or more, width*height up to 64) |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | 1 = write to shared memory, 0 = read |
| bus_addr | output | 16 | Word address on the shared bus |
| bus_wdata | output | 16 | Write data |
| bus_gnt | input | 1 | Grant; one word moves in each cycle with request and grant |
| bus_rdata | input | 16 | Read data, valid in the granted cycle |
| cpu_ready | output | 1 | Compute buffer holds a segment and accepts access |
| cpu_sel | output | 1 | Which buffer faces the compute engine |
| cpu_we | input | 1 | Compute write strobe |
| cpu_addr | input | 6 | Local word index |
| cpu_wdata | input | 16 | Compute write data |
| cpu_rdata | output | 16 | Compute read data (combinational) |
| cpu_seg_done | input | 1 | Compute engine has finished its segment |

## Verification
The hardest situations to reach are the two orders in which a swap can be held up. In one, the compute engine finishes while the other buffer is still unloading or loading. In the other, the bus side is idle and waits for the compute engine. The bench reaches both by running jobs with a sparse random grant against random compute delays, and again with a permanent grant and no delay. Right after each accepted segment end, the compute side drives a stray write and a stray segment end while `cpu_ready` is low. The stray write targets the buffer whose results have not yet been unloaded, so any leak shows up as a wrong word on the bus.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 16;
  localparam int BUF_WORDS = 64;
  localparam int CNT_W     = 8;
  localparam int LIDX_W    = $clog2(BUF_WORDS);
  localparam int DIM_W     = LIDX_W + 1;

  typedef struct packed {
    logic [ADDR_W-1:0] in_base;
    logic [ADDR_W-1:0] out_base;
    logic [ADDR_W-1:0] stride;
    logic [DIM_W-1:0]  width;
    logic [DIM_W-1:0]  height;
  } seg_desc_t;

  typedef enum logic [1:0] {
    E_IDLE = 2'd0,
    E_UNLD = 2'd1,
    E_GAP  = 2'd2,
    E_LOAD = 2'd3
  } eng_state_t;
endpackage

// File: rtl/pp_buffer.sv
module pp_buffer #(
  parameter int DEPTH = 64,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/pp_xfer_engine.sv
module pp_xfer_engine
  import pp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              do_unload,
  input  logic              do_load,
  input  seg_desc_t         nxt_desc,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] buf_rdata,
  output logic              busy,
  output logic              fin,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              buf_we,
  output logic [LIDX_W-1:0] buf_addr,
  output logic [DATA_W-1:0] buf_wdata
);
  eng_state_t        st_q, st_d;
  seg_desc_t         cur_q, cur_d;
  seg_desc_t         pend_q, pend_d;
  logic              pend_ld_q, pend_ld_d;
  logic [DIM_W-1:0]  row_q, row_d, col_q, col_d;
  logic [LIDX_W-1:0] lidx_q, lidx_d;
  logic [ADDR_W-1:0] rbase_q, rbase_d;

  logic moving, last_word;

  assign moving    = ((st_q == E_UNLD) || (st_q == E_LOAD)) && bus_gnt;
  assign last_word = (col_q == cur_q.width - 1'b1) && (row_q == cur_q.height - 1'b1);

  always_comb begin
    st_d      = st_q;
    cur_d     = cur_q;
    pend_d    = pend_q;
    pend_ld_d = pend_ld_q;
    row_d     = row_q;
    col_d     = col_q;
    lidx_d    = lidx_q;
    rbase_d   = rbase_q;
    unique case (st_q)
      E_IDLE: begin
        if (start) begin
          pend_d    = nxt_desc;
          pend_ld_d = do_load;
          row_d     = '0;
          col_d     = '0;
          lidx_d    = '0;
          if (do_unload) begin
            st_d    = E_UNLD;
            rbase_d = cur_q.out_base;
          end else if (do_load) begin
            st_d    = E_LOAD;
            cur_d   = nxt_desc;
            rbase_d = nxt_desc.in_base;
          end
        end
      end
      E_UNLD, E_LOAD: begin
        if (moving) begin
          if (last_word) begin
            st_d = ((st_q == E_UNLD) && pend_ld_q) ? E_GAP : E_IDLE;
          end else begin
            lidx_d = lidx_q + 1'b1;
            if (col_q == cur_q.width - 1'b1) begin
              col_d   = '0;
              row_d   = row_q + 1'b1;
              rbase_d = rbase_q + cur_q.stride;
            end else begin
              col_d = col_q + 1'b1;
            end
          end
        end
      end
      E_GAP: begin
        cur_d   = pend_q;
        rbase_d = pend_q.in_base;
        row_d   = '0;
        col_d   = '0;
        lidx_d  = '0;
        st_d    = E_LOAD;
      end
      default: st_d = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= E_IDLE;
      cur_q     <= '0;
      pend_q    <= '0;
      pend_ld_q <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      lidx_q    <= '0;
      rbase_q   <= '0;
    end else begin
      st_q      <= st_d;
      cur_q     <= cur_d;
      pend_q    <= pend_d;
      pend_ld_q <= pend_ld_d;
      row_q     <= row_d;
      col_q     <= col_d;
      lidx_q    <= lidx_d;
      rbase_q   <= rbase_d;
    end
  end

  assign busy      = (st_q != E_IDLE);
  assign fin       = moving && last_word && !((st_q == E_UNLD) && pend_ld_q);
  assign bus_req   = (st_q == E_UNLD) || (st_q == E_LOAD);
  assign bus_we    = (st_q == E_UNLD);
  assign bus_addr  = rbase_q + ADDR_W'(col_q);
  assign bus_wdata = buf_rdata;
  assign buf_we    = (st_q == E_LOAD) && bus_gnt;
  assign buf_addr  = lidx_q;
  assign buf_wdata = bus_rdata;
endmodule

// File: rtl/pp_seq_ctrl.sv
module pp_seq_ctrl
  import pp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] seg_count,
  input  logic             seg_done,
  input  logic             x_fin,
  output logic             busy,
  output logic             done,
  output logic             cpu_ready,
  output logic             csel,
  output logic             xsel,
  output logic             launch,
  output logic             launch_tgt,
  output logic             l_unload,
  output logic             l_load,
  output logic [CNT_W-1:0] next_idx
);
  logic             busy_q, busy_d, done_q, done_d;
  logic             csel_q, csel_d, xsel_q, xsel_d;
  logic             has_q, has_d, cfin_q, cfin_d;
  logic             xrun_q, xrun_d, xld_q, xld_d, jld_q, jld_d;
  logic [CNT_W-1:0] next_q, next_d, cnt_q, cnt_d;

  logic start_ok, accept, can_swap, can_final, finish, more;

  assign cpu_ready = busy_q && has_q && !cfin_q;
  assign start_ok  = !busy_q && start && (seg_count != '0);
  assign accept    = cpu_ready && seg_done;
  assign more      = (next_q != cnt_q);
  assign can_swap  = busy_q && xld_q && !xrun_q && (!has_q || cfin_q);
  assign can_final = busy_q && has_q && cfin_q && !xrun_q && !xld_q;
  assign finish    = busy_q && !has_q && !xrun_q && !xld_q && !more;

  always_comb begin
    launch     = 1'b0;
    launch_tgt = 1'b0;
    l_unload   = 1'b0;
    l_load     = 1'b0;
    if (start_ok) begin
      launch = 1'b1;
      l_load = 1'b1;
    end else if (can_swap) begin
      launch     = has_q || more;
      launch_tgt = csel_q;
      l_unload   = has_q;
      l_load     = more;
    end else if (can_final) begin
      launch     = 1'b1;
      launch_tgt = csel_q;
      l_unload   = 1'b1;
    end
  end

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    csel_d = csel_q;
    xsel_d = launch ? launch_tgt : xsel_q;
    has_d  = has_q;
    cfin_d = cfin_q;
    xrun_d = xrun_q;
    xld_d  = xld_q;
    jld_d  = jld_q;
    next_d = next_q;
    cnt_d  = cnt_q;
    if (start_ok) begin
      busy_d = 1'b1;
      cnt_d  = seg_count;
      csel_d = 1'b1;
      has_d  = 1'b0;
      cfin_d = 1'b0;
      xrun_d = 1'b1;
      jld_d  = 1'b1;
      xld_d  = 1'b0;
      next_d = CNT_W'(1);
    end else begin
      if (accept) cfin_d = 1'b1;
      if (can_swap) begin
        csel_d = !csel_q;
        has_d  = 1'b1;
        cfin_d = 1'b0;
        xld_d  = 1'b0;
        xrun_d = launch;
        jld_d  = more;
        if (more) next_d = next_q + 1'b1;
      end
      if (can_final) begin
        has_d  = 1'b0;
        cfin_d = 1'b0;
        xrun_d = 1'b1;
        jld_d  = 1'b0;
      end
      if (x_fin && xrun_q) begin
        xrun_d = 1'b0;
        xld_d  = jld_q;
      end
      if (finish) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      csel_q <= 1'b0;
      xsel_q <= 1'b0;
      has_q  <= 1'b0;
      cfin_q <= 1'b0;
      xrun_q <= 1'b0;
      xld_q  <= 1'b0;
      jld_q  <= 1'b0;
      next_q <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      csel_q <= csel_d;
      xsel_q <= xsel_d;
      has_q  <= has_d;
      cfin_q <= cfin_d;
      xrun_q <= xrun_d;
      xld_q  <= xld_d;
      jld_q  <= jld_d;
      next_q <= next_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign csel     = csel_q;
  assign xsel     = xsel_q;
  assign next_idx = start_ok ? '0 : next_q;
endmodule

// File: rtl/pingpong_prefetch.sv
module pingpong_prefetch
  import pp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  seg_count,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  desc_idx,
  input  logic [ADDR_W-1:0] desc_in_base,
  input  logic [ADDR_W-1:0] desc_out_base,
  input  logic [ADDR_W-1:0] desc_stride,
  input  logic [DIM_W-1:0]  desc_width,
  input  logic [DIM_W-1:0]  desc_height,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              cpu_ready,
  output logic              cpu_sel,
  input  logic              cpu_we,
  input  logic [LIDX_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              cpu_seg_done
);
  localparam int NBUF = 2;

  seg_desc_t         desc;
  logic              csel, xsel, launch, launch_tgt, l_unload, l_load, x_fin;
  logic              eng_busy [NBUF];
  logic              eng_fin  [NBUF];
  logic              eng_req  [NBUF];
  logic              eng_we   [NBUF];
  logic [ADDR_W-1:0] eng_addr [NBUF];
  logic [DATA_W-1:0] eng_wd   [NBUF];
  logic              eng_bwe  [NBUF];
  logic [LIDX_W-1:0] eng_badr [NBUF];
  logic [DATA_W-1:0] eng_bwd  [NBUF];
  logic              b_we     [NBUF];
  logic [LIDX_W-1:0] b_addr   [NBUF];
  logic [DATA_W-1:0] b_wdata  [NBUF];
  logic [DATA_W-1:0] b_rdata  [NBUF];

  assign desc = '{in_base: desc_in_base, out_base: desc_out_base, stride: desc_stride,
                  width: desc_width, height: desc_height};

  pp_seq_ctrl u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .seg_count (seg_count),
    .seg_done  (cpu_seg_done),
    .x_fin     (x_fin),
    .busy      (busy),
    .done      (done),
    .cpu_ready (cpu_ready),
    .csel      (csel),
    .xsel      (xsel),
    .launch    (launch),
    .launch_tgt(launch_tgt),
    .l_unload  (l_unload),
    .l_load    (l_load),
    .next_idx  (desc_idx)
  );

  for (genvar e = 0; e < NBUF; e++) begin : g_twin
    pp_xfer_engine u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (launch && (launch_tgt == 1'(e))),
      .do_unload(l_unload),
      .do_load  (l_load),
      .nxt_desc (desc),
      .bus_gnt  (bus_gnt && (xsel == 1'(e))),
      .bus_rdata(bus_rdata),
      .buf_rdata(b_rdata[e]),
      .busy     (eng_busy[e]),
      .fin      (eng_fin[e]),
      .bus_req  (eng_req[e]),
      .bus_we   (eng_we[e]),
      .bus_addr (eng_addr[e]),
      .bus_wdata(eng_wd[e]),
      .buf_we   (eng_bwe[e]),
      .buf_addr (eng_badr[e]),
      .buf_wdata(eng_bwd[e])
    );

    assign b_we[e]    = eng_busy[e] ? eng_bwe[e]
                                    : (cpu_ready && cpu_we && (csel == 1'(e)));
    assign b_addr[e]  = eng_busy[e] ? eng_badr[e] : cpu_addr;
    assign b_wdata[e] = eng_busy[e] ? eng_bwd[e]  : cpu_wdata;

    pp_buffer #(.DEPTH(BUF_WORDS), .DW(DATA_W)) u_buf (
      .clk  (clk),
      .we   (b_we[e]),
      .addr (b_addr[e]),
      .wdata(b_wdata[e]),
      .rdata(b_rdata[e])
    );
  end

  assign x_fin     = eng_fin[xsel];
  assign bus_req   = eng_req[xsel];
  assign bus_we    = eng_we[xsel];
  assign bus_addr  = eng_addr[xsel];
  assign bus_wdata = eng_wd[xsel];
  assign cpu_rdata = b_rdata[csel];
  assign cpu_sel   = csel;
endmodule

// File: rtl/pingpong_prefetch_chk.sv
module pingpong_prefetch_chk
  import pp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              cpu_ready
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_req && !cpu_ready));

  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  a_r6_gap_before_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |=> !(bus_req && !bus_we));

  a_r9_ready_in_job: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> busy);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !bus_req));
endmodule

bind pingpong_prefetch pingpong_prefetch_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .bus_req  (bus_req),
  .bus_gnt  (bus_gnt),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .cpu_ready(cpu_ready)
);

// File: tb/pingpong_prefetch_tb_top.sv
module pingpong_prefetch_tb_top;
  import pp_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int MAXSEG     = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [CNT_W-1:0]  seg_count;
  logic              busy, done;
  logic [CNT_W-1:0]  desc_idx;
  logic [ADDR_W-1:0] desc_in_base, desc_out_base, desc_stride;
  logic [DIM_W-1:0]  desc_width, desc_height;
  logic              bus_req, bus_we, bus_gnt;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, bus_rdata;
  logic              cpu_ready, cpu_sel, cpu_we, cpu_seg_done;
  logic [LIDX_W-1:0] cpu_addr;
  logic [DATA_W-1:0] cpu_wdata, cpu_rdata;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [15:0] in_base_a  [MAXSEG];
  logic [15:0] out_base_a [MAXSEG];
  logic [15:0] stride_a   [MAXSEG];
  int          wid_a      [MAXSEG];
  int          hgt_a      [MAXSEG];

  int          gnt_pct = 100;
  int          nseg_cur = 0;
  int          rd_seg, rd_k, wr_seg, wr_k, cyc, last_wr_cyc, done_seen;
  bit          req_low_seen, prev_wait, prev_we;
  logic [15:0] prev_addr;

  pingpong_prefetch dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .seg_count(seg_count),
    .busy(busy), .done(done), .desc_idx(desc_idx),
    .desc_in_base(desc_in_base), .desc_out_base(desc_out_base),
    .desc_stride(desc_stride), .desc_width(desc_width), .desc_height(desc_height),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
    .cpu_ready(cpu_ready), .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_seg_done(cpu_seg_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] src_word(logic [15:0] a);
    return a * 16'd37 + 16'd11;
  endfunction

  function automatic logic [15:0] gaddr(logic [15:0] base, logic [15:0] stride, int k, int w);
    return base + 16'(k / w) * stride + 16'(k % w);
  endfunction

  function automatic logic [15:0] res_word(int s, int k, logic [15:0] v);
    return (v ^ 16'h5A5A) + 16'(s * 256 + k);
  endfunction

  always_comb begin
    desc_in_base  = in_base_a[desc_idx[2:0]];
    desc_out_base = out_base_a[desc_idx[2:0]];
    desc_stride   = stride_a[desc_idx[2:0]];
    desc_width    = DIM_W'(wid_a[desc_idx[2:0]]);
    desc_height   = DIM_W'(hgt_a[desc_idx[2:0]]);
  end

  assign bus_rdata = src_word(bus_addr);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus responder and monitor: grant at negedge, observe 1 time unit later
  initial begin
    bus_gnt = 1'b0;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      bus_gnt = ($urandom_range(99) < gnt_pct);
      #1;
      if (prev_wait) begin
        chk(bus_req && (bus_addr == prev_addr) && (bus_we == prev_we),
            "R5 request held with stable address", {bus_req, bus_addr}, {1'b1, prev_addr});
      end
      if (!bus_req) req_low_seen = 1'b1;
      if (bus_req && bus_gnt) begin
        if (bus_we) begin
          if (wr_seg < nseg_cur) begin
            automatic int s = wr_seg;
            automatic logic [15:0] ea = gaddr(out_base_a[s], stride_a[s], wr_k, wid_a[s]);
            automatic logic [15:0] ed = res_word(s, wr_k,
                                     src_word(gaddr(in_base_a[s], stride_a[s], wr_k, wid_a[s])));
            chk(bus_addr == ea, "R4 unload address", bus_addr, ea);
            chk(bus_wdata == ed, "R4 unload data", bus_wdata, ed);
            wr_k++;
            if (wr_k == wid_a[s] * hgt_a[s]) begin
              wr_k = 0;
              wr_seg++;
              last_wr_cyc = cyc;
              req_low_seen = 1'b0;
            end
          end else chk(1'b0, "R4 unexpected write", bus_addr, 0);
        end else begin
          if (rd_seg < nseg_cur) begin
            automatic int s = rd_seg;
            automatic logic [15:0] ea = gaddr(in_base_a[s], stride_a[s], rd_k, wid_a[s]);
            chk(bus_addr == ea, "R3 load address", bus_addr, ea);
            if (rd_k == 0 && s >= 2) begin
              chk(wr_seg >= s - 1, "R8 unload before load", wr_seg, s - 1);
              chk(req_low_seen, "R6 request gap before load", req_low_seen, 1);
            end
            rd_k++;
            if (rd_k == wid_a[s] * hgt_a[s]) begin
              rd_k = 0;
              rd_seg++;
            end
          end else chk(1'b0, "R7 unexpected read", bus_addr, 0);
        end
      end
      prev_wait = bus_req && !bus_gnt;
      prev_addr = bus_addr;
      prev_we   = bus_we;
      if (done) begin
        done_seen++;
        chk(cyc - last_wr_cyc == 2, "R10 done two cycles after last write", cyc - last_wr_cyc, 2);
        chk(!busy, "R10 busy falls with done", busy, 0);
      end
    end
  end

  task automatic set_random(input int n);
    for (int i = 0; i < n; i++) begin
      wid_a[i]      = $urandom_range(1, 8);
      hgt_a[i]      = $urandom_range(1, 8);
      stride_a[i]   = 16'(wid_a[i] + $urandom_range(0, 4));
      in_base_a[i]  = 16'($urandom_range(0, 1023));
      out_base_a[i] = 16'($urandom_range(2048, 3071));
    end
  endtask

  task automatic run_job(input int n, input int gp, input int slow);
    @(negedge clk);
    gnt_pct = gp; nseg_cur = n;
    rd_seg = 0; rd_k = 0; wr_seg = 0; wr_k = 0; done_seen = 0;
    req_low_seen = 1'b0; prev_wait = 1'b0;
    seg_count = CNT_W'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R2 busy after start", busy, 1);
    seg_count = CNT_W'(3); start = 1'b1;   // R2: ignored while busy
    @(negedge clk);
    start = 1'b0;
    for (int s = 0; s < n; s++) begin
      while (!cpu_ready && !finished) @(negedge clk);
      chk(cpu_sel == s[0], "R7 buffer alternation", cpu_sel, s[0]);
      chk(rd_seg >= s + 1, "R9 ready only after full load", rd_seg, s + 1);
      for (int k = 0; k < wid_a[s] * hgt_a[s]; k++) begin
        automatic logic [15:0] ev;
        cpu_we = 1'b0;
        cpu_addr = LIDX_W'(k);
        #1;
        ev = src_word(gaddr(in_base_a[s], stride_a[s], k, wid_a[s]));
        chk(cpu_rdata == ev, "R3 loaded word at row*width+col", cpu_rdata, ev);
        cpu_we = 1'b1;
        cpu_wdata = res_word(s, k, ev);
        @(negedge clk);
      end
      cpu_we = 1'b0;
      if (slow > 0) repeat ($urandom_range(0, slow * 15)) @(negedge clk);
      cpu_seg_done = 1'b1;
      @(negedge clk);
      cpu_seg_done = 1'b0;
      chk(!cpu_ready, "R9 stall after segment end", cpu_ready, 0);
      // R11: stray write and stray segment end while not ready
      cpu_we = 1'b1; cpu_addr = '0; cpu_wdata = 16'hDEAD; cpu_seg_done = 1'b1;
      @(negedge clk);
      cpu_we = 1'b0; cpu_seg_done = 1'b0;
    end
    for (int t = 0; t < 3000 && done_seen == 0 && !finished; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done_seen == 1, "R10 single done pulse", done_seen, 1);
    chk(!busy, "R10 idle after job", busy, 0);
    chk(wr_seg == n, "R4 all segments unloaded", wr_seg, n);
    chk(rd_seg == n, "R7 all segments loaded once", rd_seg, n);
  endtask

  initial begin
    void'($urandom(32'd7321));
    rst_n = 1'b0; start = 1'b0; seg_count = '0;
    cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_seg_done = 1'b0;
    rd_seg = 0; rd_k = 0; wr_seg = 0; wr_k = 0; last_wr_cyc = 0; done_seen = 0;
    req_low_seen = 1'b0; prev_wait = 1'b0; prev_we = 1'b0; prev_addr = '0;
    for (int i = 0; i < MAXSEG; i++) begin
      wid_a[i] = 1; hgt_a[i] = 1; stride_a[i] = 16'd1;
      in_base_a[i] = '0; out_base_a[i] = 16'd2048;
    end
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1 reset busy/done", {busy, done}, 0);
    chk(!bus_req && !cpu_ready, "R1 reset bus/compute quiet", {bus_req, cpu_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: zero-length job ignored
    seg_count = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy && !bus_req && !done, "R2 zero count ignored", {busy, bus_req, done}, 0);

    // directed: single 1x1 segment
    wid_a[0] = 1; hgt_a[0] = 1; stride_a[0] = 16'd1;
    in_base_a[0] = 16'd100; out_base_a[0] = 16'd3000;
    run_job(1, 100, 0);

    // directed: full buffer then a small overlapping segment
    wid_a[0] = 8; hgt_a[0] = 8; stride_a[0] = 16'd12;
    in_base_a[0] = 16'd200; out_base_a[0] = 16'd2500;
    wid_a[1] = 3; hgt_a[1] = 2; stride_a[1] = 16'd3;
    in_base_a[1] = 16'd213; out_base_a[1] = 16'd2600;
    run_job(2, 50, 1);

    set_random(6);
    run_job(6, 35, 1);
    set_random(5);
    run_job(5, 100, 0);
    set_random(8);
    run_job(8, 70, 2);

    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule